// File: doc/BRIEF.md
# Register Rename Map with Reorder Buffer Tags

This block tracks, for every architectural register, whether its newest value is still in flight. Each entry is either idle, meaning the register file already holds the current value, or busy with the reorder buffer tag of the youngest instruction that will produce it. When an instruction issues, its destination entry is loaded with the tag that instruction was given in the reorder buffer. Two lookup ports let the issue stage find out, for each source operand, whether to read the register file or to wait on a tag.

At commit the register file is always written, whatever this table holds. The table only decides whether the mapping can be dropped. It drops the mapping only when the committing tag is still the one recorded; a mismatch means a younger producer now owns the register. On a mispredicted branch a single flush input drops every mapping at once, so all registers point back to the register file.

Top module: `rename_map`

## Requirements
- R1: With `ren_en` high at a clock edge, the entry for `ren_reg` becomes busy with tag `ren_tag`, and lookups of that register show it from the next cycle.
- R2: A lookup of an idle entry returns busy 0 and tag 0; a busy entry returns busy 1 and its tag. The two lookup ports are independent.
- R3: A commit (`cmt_en`) whose `cmt_tag` equals the tag held by a busy entry `cmt_reg` makes that entry idle at the edge.
- R4: A commit whose tag differs from the tag held by the entry leaves the entry busy with its tag unchanged.
- R5: A commit to an idle entry has no effect on it.
- R6: `flush` high at an edge makes every entry idle.
- R7: `flush` overrides a rename in the same cycle: the renamed register is idle afterwards.
- R8: If a rename and a commit name the same register in the same cycle, the rename wins: the entry holds the new tag.
- R9: Lookups are combinational and show the state before any write made at the coming edge.
- R10: An active-low `rst_n` makes every entry idle, asynchronously.
- R11: A rename and a commit to different registers in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a_reg | input | 4 | First lookup register |
| src_a_busy | output | 1 | First lookup: value in flight |
| src_a_tag | output | 3 | First lookup: tag to wait on (0 when idle) |
| src_b_reg | input | 4 | Second lookup register |
| src_b_busy | output | 1 | Second lookup: value in flight |
| src_b_tag | output | 3 | Second lookup: tag to wait on (0 when idle) |
| ren_en | input | 1 | Rename write enable |
| ren_reg | input | 4 | Destination register being renamed |
| ren_tag | input | 3 | Reorder buffer tag of the new producer |
| cmt_en | input | 1 | Commit clear enable |
| cmt_reg | input | 4 | Destination register of the committing instruction |
| cmt_tag | input | 3 | Tag of the committing instruction |
| flush | input | 1 | Drop every mapping (misprediction recovery) |

## Verification
A wrong entry shows up at a lookup port in the cycle after the faulty write: a stale busy bit sends a consumer to wait on a tag that never arrives, and a wrongly cleared entry sends it to a register file that is not yet current. The bench therefore reads back the affected register, and an unrelated one, right after each rename, matching commit, stale commit, collision and flush. Lookups are also sampled in the same cycle as writes to show they carry the old state.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NREG = 16,
  parameter int TAGW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] src_a_reg,
  output logic                    src_a_busy,
  output logic [TAGW-1:0]         src_a_tag,
  input  logic [$clog2(NREG)-1:0] src_b_reg,
  output logic                    src_b_busy,
  output logic [TAGW-1:0]         src_b_tag,
  input  logic                    ren_en,
  input  logic [$clog2(NREG)-1:0] ren_reg,
  input  logic [TAGW-1:0]         ren_tag,
  input  logic                    cmt_en,
  input  logic [$clog2(NREG)-1:0] cmt_reg,
  input  logic [TAGW-1:0]         cmt_tag,
  input  logic                    flush
);
  localparam int REGW = $clog2(NREG);

  logic [NREG-1:0] busy_q;
  logic [TAGW-1:0] tag_q [NREG];

  assign src_a_busy = busy_q[src_a_reg];
  assign src_a_tag  = busy_q[src_a_reg] ? tag_q[src_a_reg] : '0;
  assign src_b_busy = busy_q[src_b_reg];
  assign src_b_tag  = busy_q[src_b_reg] ? tag_q[src_b_reg] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int i = 0; i < NREG; i++) tag_q[i] <= '0;
    end else if (flush) begin
      busy_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ren_en && ren_reg == REGW'(i)) begin
          busy_q[i] <= 1'b1;
          tag_q[i]  <= ren_tag;
        end else if (cmt_en && cmt_reg == REGW'(i) && busy_q[i] && tag_q[i] == cmt_tag) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end

  AST_RENAME_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en && !flush |=> (src_a_reg != $past(ren_reg)) || (src_a_busy && src_a_tag == $past(ren_tag))); // R1

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_en && !flush && !(ren_en && ren_reg == cmt_reg) && busy_q[cmt_reg] && tag_q[cmt_reg] == cmt_tag
    |=> !busy_q[$past(cmt_reg)]); // R3

  AST_STALE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_en && !flush && busy_q[cmt_reg] && tag_q[cmt_reg] != cmt_tag
    |=> busy_q[$past(cmt_reg)]); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !src_a_busy && !src_b_busy && busy_q == '0); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !ren_en && !cmt_en |=> $stable(busy_q)); // R5

  always_comb begin
    if (rst_n && !src_a_busy) AST_IDLE_TAG_ZERO: assert (src_a_tag == '0); // R2
  end
endmodule

// File: tb/rename_map_bench.sv
module rename_map_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_a_reg = '0, src_b_reg = '0, ren_reg = '0, cmt_reg = '0;
  logic [2:0] ren_tag = '0, cmt_tag = '0;
  logic ren_en = 1'b0, cmt_en = 1'b0, flush = 1'b0;
  logic src_a_busy, src_b_busy;
  logic [2:0] src_a_tag, src_b_tag;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rename_map u_rename_map (.*);

  typedef struct packed {
    logic       ren_en; logic [3:0] ren_reg; logic [2:0] ren_tag;
    logic       cmt_en; logic [3:0] cmt_reg; logic [2:0] cmt_tag;
    logic       flush;
    logic [3:0] a_reg;  logic a_busy; logic [2:0] a_tag;
    logic [3:0] b_reg;  logic b_busy; logic [2:0] b_tag;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  // Lookups are checked before the edge that applies the row's writes.
  localparam vec_t VEC [NV] = '{
    '{1,3,5, 0,0,0, 0,  3,0,0,  0,0,0,  9},  // R9 rename r3 not yet visible
    '{1,7,2, 0,0,0, 0,  3,1,5,  7,0,0,  1},  // R1
    '{0,0,0, 1,3,1, 0,  7,1,2,  3,1,5,  2},  // R2 stale commit on r3
    '{0,0,0, 0,0,0, 0,  3,1,5,  7,1,2,  4},  // R4 r3 kept
    '{1,9,6, 1,3,5, 0,  3,1,5,  9,0,0, 11},  // R11 commit r3 + rename r9
    '{0,0,0, 0,0,0, 0,  3,0,0,  9,1,6,  3},  // R3 r3 cleared, R11 r9 set
    '{1,9,1, 1,9,6, 0,  9,1,6,  5,0,0,  8},  // R8 collision on r9
    '{0,0,0, 0,0,0, 0,  9,1,1,  7,1,2,  8},  // R8 new tag wins
    '{1,15,7,1,5,0, 0,  7,1,2,  9,1,1,  5},  // R5 commit to idle r5
    '{0,0,0, 0,0,0, 0,  5,0,0, 15,1,7,  5},  // R5 r5 idle, r15 set
    '{1,0,3, 0,0,0, 1, 15,1,7,  7,1,2,  7},  // R7 flush with rename
    '{0,0,0, 0,0,0, 0,  0,0,0, 15,0,0,  6},  // R7 r0 idle, R6 r15 idle
    '{0,0,0, 0,0,0, 0,  7,0,0,  9,0,0,  6}   // R6
  };

  task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic look(input string rq, input logic [3:0] ra, input logic eb, input logic [2:0] et);
    src_a_reg = ra;
    #1;
    check(rq, {src_a_busy, src_a_tag}, {eb, et});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    look("R10", 4'd0, 0, 3'd0);
    look("R10", 4'd15, 0, 3'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ren_en = VEC[i].ren_en; ren_reg = VEC[i].ren_reg; ren_tag = VEC[i].ren_tag;
      cmt_en = VEC[i].cmt_en; cmt_reg = VEC[i].cmt_reg; cmt_tag = VEC[i].cmt_tag;
      flush  = VEC[i].flush;
      src_a_reg = VEC[i].a_reg; src_b_reg = VEC[i].b_reg;
      #2;
      check($sformatf("R%0d row%0d port a", VEC[i].req, i), {src_a_busy, src_a_tag}, {VEC[i].a_busy, VEC[i].a_tag});
      check($sformatf("R%0d row%0d port b", VEC[i].req, i), {src_b_busy, src_b_tag}, {VEC[i].b_busy, VEC[i].b_tag});
    end
    // R1/R2 boundary tag values, then R10 asynchronous reset
    @(negedge clk); ren_en = 1; ren_reg = 4'd12; ren_tag = 3'd0; flush = 0; cmt_en = 0;
    @(negedge clk); ren_reg = 4'd4; ren_tag = 3'd7;
    @(negedge clk); ren_en = 0;
    look("R1", 4'd12, 1, 3'd0);
    look("R2", 4'd4, 1, 3'd7);
    #1 rst_n = 1'b0;
    #1;
    look("R10", 4'd4, 0, 3'd0);
    look("R10", 4'd12, 0, 3'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule